// File: doc/BRIEF.md
# Dual-Channel High/Low Count PWM Generator

This block produces two independent pulse-width-modulated outputs whose waveform is defined directly by two lengths, a high phase and a low phase, each counted in prescaled ticks. Each channel picks one of four tick-enable inputs as its timebase. It divides that timebase by a programmable amount and then alternates between a high phase and a low phase. Software sets up the channels through three 32-bit registers on a simple single-cycle read/write bus: one count register per channel and one control register that both channels share.

A channel runs only while its clock enable and its output enable are both set. When either is cleared, the output drops to zero at once and the phase sequencer returns to idle. On the next enable the sequencer restarts at the start of a high phase. Software may rewrite a count register while its channel is running. The new lengths are taken up at the next period boundary, so a period in progress always runs to its programmed length. The block has no polarity control. To invert a waveform, software swaps the two lengths.

Top module: `dual_pwm_gen`

## Requirements
- R1: After reset all three registers read zero and both `pwm_out` bits are low.
- R2: The registers sit at these byte offsets: 0x0 is the channel 0 count register, 0x4 is the channel 1 count register and 0x8 is the control register. A count register holds the high length in bits [31:16] and the low length in bits [15:0]. In the control register, bit 0 and bit 1 are the output enables of channel 0 and channel 1. Bits [5:4] and [7:6] are their clock selects. Bits [14:8] and [22:16] are their prescalers. Bit 15 and bit 23 are their clock enables. Every other control bit reads zero, and any other offset reads zero.
- R3: The clock select value S makes the channel count ticks of `src_tick[S]` only. A prescaler value N turns N+1 selected ticks into one phase tick.
- R4: A running channel drives high for H phase ticks and then low for L phase ticks, and repeats this, where H and L come from its count register. Each run begins at the start of a high phase.
- R5: When L is 0 the output stays high. When H is 0 the output stays low.
- R6: While its clock enable or its output enable is clear, a channel's output is 0.
- R7: Clearing a channel's enable forces its output low right after the clock edge that writes the control register, even in the middle of a period. The next enable restarts the sequence from a fresh high phase.
- R8: A count register written while its channel runs takes effect at the next period boundary. The current period is not cut short.
- R9: The two channels run independently. Programming or running one channel does not affect the other channel's output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe, one transfer per cycle |
| bus_addr | input | 4 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| src_tick | input | 4 | Tick-enable inputs of the four timebases |
| pwm_out | output | 2 | PWM output, bit i belongs to channel i |

## Verification
The assertions take for granted that `src_tick` is a synchronous, single-cycle enable sampled on `clk`. They also take for granted that the bus address is stable whenever the read data is examined. The bench drives every input on the falling edge and holds the four tick inputs at fixed levels: two are always active and two never tick. With the inputs held that way, a phase tick comes either on every N+1 cycles or never. Expected waveforms therefore follow from plain arithmetic on H, L and N.

The sweep covers every combination of H and L from 0 to 3 and every prescaler value from 0 to 2 on one channel, and checks that the idle channel stays low throughout. Separate runs cover the constant-output cases, a live count rewrite, a disable in the middle of a period, clock select and the clock-enable gate.

// File: rtl/dpwm_pkg.sv
package dpwm_pkg;

    localparam int NUM_CH  = 2;
    localparam int DATA_W  = 32;
    localparam int ADDR_W  = 4;
    localparam int CNT_W   = 16;
    localparam int PRE_W   = 7;
    localparam int SEL_W   = 2;
    localparam int NUM_SRC = 1 << SEL_W;

    localparam logic [ADDR_W-1:0] OFS_CTRL = ADDR_W'(8);

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_HIGH = 2'd1,
        PH_LOW  = 2'd2
    } phase_e;

    // Control register field positions, per channel
    function automatic int oe_bit(input int ch);
        return ch;
    endfunction

    function automatic int sel_lsb(input int ch);
        return 4 + SEL_W * ch;
    endfunction

    function automatic int pre_lsb(input int ch);
        return 8 + 8 * ch;
    endfunction

    function automatic int cken_bit(input int ch);
        return 15 + 8 * ch;
    endfunction

    function automatic logic [ADDR_W-1:0] count_ofs(input int ch);
        return ADDR_W'(4 * ch);
    endfunction

    function automatic logic [DATA_W-1:0] ctrl_mask();
        logic [DATA_W-1:0] m;
        m = '0;
        for (int ch = 0; ch < NUM_CH; ch++) begin
            m[oe_bit(ch)]   = 1'b1;
            m[cken_bit(ch)] = 1'b1;
            for (int b = 0; b < SEL_W; b++) m[sel_lsb(ch) + b] = 1'b1;
            for (int b = 0; b < PRE_W; b++) m[pre_lsb(ch) + b] = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/dpwm_regs.sv
module dpwm_regs
    import dpwm_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [ADDR_W-1:0]             addr,
    input  logic [DATA_W-1:0]             wdata,
    output logic [NUM_CH-1:0][DATA_W-1:0] count_q,
    output logic [DATA_W-1:0]             ctrl_q,
    output logic [DATA_W-1:0]             rdata
);

    localparam logic [DATA_W-1:0] CTRL_MASK = ctrl_mask();

    // Shared control register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (wr_en && addr == OFS_CTRL) begin
            ctrl_q <= wdata & CTRL_MASK;
        end
    end

    // One count register per channel
    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_count
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                count_q[ch] <= '0;
            end else if (wr_en && addr == count_ofs(ch)) begin
                count_q[ch] <= wdata;
            end
        end
    end

    // Read multiplexer, unknown offsets return zero
    always_comb begin
        rdata = '0;
        if (addr == OFS_CTRL) rdata = ctrl_q;
        for (int ch = 0; ch < NUM_CH; ch++) begin
            if (addr == count_ofs(ch)) rdata = count_q[ch];
        end
    end

endmodule

// File: rtl/dpwm_prescaler.sv
module dpwm_prescaler
    import dpwm_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               run,
    input  logic [SEL_W-1:0]   sel,
    input  logic [PRE_W-1:0]   pre,
    input  logic [NUM_SRC-1:0] src_tick,
    output logic               ptick
);

    logic [PRE_W-1:0] div_q;
    logic             tick_sel;
    logic             wrap;

    assign tick_sel = src_tick[sel];
    // >= keeps the divider bounded if the prescaler is lowered on the fly
    assign wrap     = (div_q >= pre);
    assign ptick    = run && tick_sel && wrap;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q <= '0;
        end else if (!run) begin
            div_q <= '0;
        end else if (tick_sel) begin
            div_q <= wrap ? '0 : div_q + 1'b1;
        end
    end

endmodule

// File: rtl/dpwm_phase_fsm.sv
module dpwm_phase_fsm
    import dpwm_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             active,
    input  logic             ptick,
    input  logic [CNT_W-1:0] cfg_hi,
    input  logic [CNT_W-1:0] cfg_lo,
    output logic             running,
    output logic             out
);

    phase_e           state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [CNT_W-1:0] hi_q, hi_d;
    logic [CNT_W-1:0] lo_q, lo_d;
    logic [CNT_W:0]   cnt_inc;
    phase_e           start_phase;

    assign cnt_inc     = {1'b0, cnt_q} + 1'b1;
    assign start_phase = (cfg_hi != '0) ? PH_HIGH : PH_LOW;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        hi_d    = hi_q;
        lo_d    = lo_q;
        if (!active) begin
            state_d = PH_IDLE;
            cnt_d   = '0;
        end else begin
            unique case (state_q)
                PH_IDLE: begin
                    hi_d    = cfg_hi;
                    lo_d    = cfg_lo;
                    cnt_d   = '0;
                    state_d = start_phase;
                end
                PH_HIGH: begin
                    if (ptick) begin
                        if (cnt_inc >= {1'b0, hi_q}) begin
                            cnt_d = '0;
                            if (lo_q != '0) begin
                                state_d = PH_LOW;
                            end else begin
                                hi_d    = cfg_hi;
                                lo_d    = cfg_lo;
                                state_d = start_phase;
                            end
                        end else begin
                            cnt_d = cnt_inc[CNT_W-1:0];
                        end
                    end
                end
                PH_LOW: begin
                    if (ptick) begin
                        if (cnt_inc >= {1'b0, lo_q}) begin
                            cnt_d   = '0;
                            hi_d    = cfg_hi;
                            lo_d    = cfg_lo;
                            state_d = start_phase;
                        end else begin
                            cnt_d = cnt_inc[CNT_W-1:0];
                        end
                    end
                end
                default: begin
                    state_d = PH_IDLE;
                    cnt_d   = '0;
                end
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PH_IDLE;
            cnt_q   <= '0;
            hi_q    <= '0;
            lo_q    <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            hi_q    <= hi_d;
            lo_q    <= lo_d;
        end
    end

    // Outputs: gated by the live enable so a disable lands at once
    always_comb begin
        running = (state_q != PH_IDLE);
        out     = active && (state_q == PH_HIGH);
    end

endmodule

// File: rtl/dual_pwm_gen.sv
module dual_pwm_gen
    import dpwm_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_wr,
    input  logic [3:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    input  logic [3:0]  src_tick,
    output logic [1:0]  pwm_out
);

    logic [NUM_CH-1:0][DATA_W-1:0] count_q;
    logic [DATA_W-1:0]             ctrl_q;
    logic [NUM_CH-1:0]             active;
    logic [NUM_CH-1:0]             ptick;
    logic [NUM_CH-1:0]             running;

    dpwm_regs u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (bus_wr),
        .addr    (bus_addr),
        .wdata   (bus_wdata),
        .count_q (count_q),
        .ctrl_q  (ctrl_q),
        .rdata   (bus_rdata)
    );

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        assign active[ch] = ctrl_q[oe_bit(ch)] && ctrl_q[cken_bit(ch)];

        dpwm_prescaler u_pre (
            .clk      (clk),
            .rst_n    (rst_n),
            .run      (running[ch]),
            .sel      (ctrl_q[sel_lsb(ch) +: SEL_W]),
            .pre      (ctrl_q[pre_lsb(ch) +: PRE_W]),
            .src_tick (src_tick),
            .ptick    (ptick[ch])
        );

        dpwm_phase_fsm u_fsm (
            .clk     (clk),
            .rst_n   (rst_n),
            .active  (active[ch]),
            .ptick   (ptick[ch]),
            .cfg_hi  (count_q[ch][DATA_W-1 -: CNT_W]),
            .cfg_lo  (count_q[ch][CNT_W-1:0]),
            .running (running[ch]),
            .out     (pwm_out[ch])
        );
    end

endmodule

// File: rtl/dual_pwm_gen_checker.sv
module dual_pwm_gen_checker
    import dpwm_pkg::*;
(
    input logic                clk,
    input logic                rst_n,
    input logic [3:0]          bus_addr,
    input logic [31:0]         bus_rdata,
    input logic [NUM_CH-1:0]   active,
    input logic [NUM_CH-1:0]   ptick,
    input logic [NUM_CH-1:0]   running,
    input logic [1:0]          pwm_out
);

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chk
        // R6: a channel that is not enabled drives 0
        assert_off_when_gated_R6: assert property (@(posedge clk) disable iff (!rst_n)
            !active[ch] |-> !pwm_out[ch]);

        // R3 / R4: during a run the output only moves on a phase tick
        assert_edge_on_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (active[ch] && $past(active[ch]) && $past(running[ch])
             && (pwm_out[ch] != $past(pwm_out[ch]))) |-> $past(ptick[ch]));

        // R7: a disable returns the sequencer to idle
        assert_idle_after_disable_R7: assert property (@(posedge clk) disable iff (!rst_n)
            !$past(active[ch]) |-> !running[ch]);

        // R7: a fresh enable starts the sequencer on the next edge
        assert_start_after_enable_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (active[ch] && !running[ch]) |=> (running[ch] || !active[ch]));
    end

    // R2: reserved control bits and unmapped offsets read zero
    assert_ctrl_reserved_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == 4'h8) |-> (bus_rdata[31:24] == 8'h0 && bus_rdata[3:2] == 2'b00));

    assert_unmapped_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr != 4'h0 && bus_addr != 4'h4 && bus_addr != 4'h8) |-> (bus_rdata == 32'h0));

endmodule

bind dual_pwm_gen dual_pwm_gen_checker u_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_rdata (bus_rdata),
    .active    (active),
    .ptick     (ptick),
    .running   (running),
    .pwm_out   (pwm_out)
);

// File: tb/test_dual_pwm_gen.sv
module test_dual_pwm_gen;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = 4'h0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [3:0]  src_tick = 4'b0101;   // sources 0 and 2 always tick, 1 and 3 never
    logic [1:0]  pwm_out;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #4 clk = ~clk;   // 125 MHz

    dual_pwm_gen i_dual_pwm_gen (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .src_tick  (src_tick),
        .pwm_out   (pwm_out)
    );

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run hung, actual=%0d cycles expected<150000", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    // Expected level t cycles after the run's first sample
    function automatic bit model(int hi, int lo, int pre, int t);
        int per;
        if (hi == 0) return 1'b0;
        if (lo == 0) return 1'b1;
        per = (hi + lo) * (pre + 1);
        return (t % per) < hi * (pre + 1);
    endfunction

    function automatic logic [31:0] ctrl_word(int ch, int sel, int pre, bit cken, bit oe);
        logic [31:0] w;
        w = '0;
        w[ch]            = oe;
        w[15 + 8 * ch]   = cken;
        w[4 + 2 * ch +: 2] = sel[1:0];
        w[8 + 8 * ch +: 7] = pre[6:0];
        return w;
    endfunction

    task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic check_read(input logic [3:0] a, input logic [31:0] exp, input string req);
        bus_addr = a;
        #1;
        checks++;
        if (bus_rdata !== exp) begin
            errors++;
            $display("FAIL %s: read 0x%0h actual=0x%08h expected=0x%08h", req, a, bus_rdata, exp);
        end
    endtask

    task automatic check_bit(input bit act, input bit exp, input string req, input int t);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: cycle %0d actual=%0b expected=%0b", req, t, act, exp);
        end
    endtask

    // Restart channel ch with the given setup and compare n cycles of output
    task automatic run_one(input int ch, input int hi, input int lo, input int pre,
                           input int n, input string req);
        bit bad;
        bus_write(4'h8, 32'h0);
        bus_write(4'(4 * ch), {16'(hi), 16'(lo)});
        bus_write(4'h8, ctrl_word(ch, 0, pre, 1'b1, 1'b1));
        @(negedge clk);
        bad = 1'b0;
        checks++;
        for (int t = 0; t < n; t++) begin
            if (!bad && (pwm_out[ch] !== model(hi, lo, pre, t) || pwm_out[1-ch] !== 1'b0)) begin
                bad = 1'b1;
                errors++;
                $display("FAIL %s: hi=%0d lo=%0d pre=%0d t=%0d actual=%b expected ch%0d=%0b other=0",
                         req, hi, lo, pre, t, pwm_out, ch, model(hi, lo, pre, t));
            end
            @(negedge clk);
        end
    endtask

    initial begin
        bit bad;
        repeat (3) @(negedge clk);
        // R1: reset state
        check_read(4'h0, 32'h0, "R1");
        check_read(4'h4, 32'h0, "R1");
        check_read(4'h8, 32'h0, "R1");
        check_bit(pwm_out[0], 1'b0, "R1", 0);
        check_bit(pwm_out[1], 1'b0, "R1", 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2: register map, readback and reserved bits
        bus_write(4'h0, 32'hDEAD_BEEF);
        bus_write(4'h4, 32'h1234_5678);
        check_read(4'h0, 32'hDEAD_BEEF, "R2");
        check_read(4'h4, 32'h1234_5678, "R2");
        bus_write(4'h8, 32'hFFFF_FFFC);   // both output enables left clear
        check_read(4'h8, 32'h00FF_FFF0, "R2");
        check_read(4'hC, 32'h0, "R2");
        check_read(4'h2, 32'h0, "R2");
        check_bit(pwm_out[0], 1'b0, "R6", 0);
        check_bit(pwm_out[1], 1'b0, "R6", 0);
        bus_write(4'h8, 32'h0);

        // R4 / R5 / R3 / R9: sweep on channel 0, then a few on channel 1
        for (int hi = 0; hi < 4; hi++)
            for (int lo = 0; lo < 4; lo++)
                for (int pre = 0; pre < 3; pre++)
                    run_one(0, hi, lo, pre, 40, "R4_R5_R3_R9");
        run_one(1, 2, 3, 1, 40, "R4_R9");
        run_one(1, 0, 5, 0, 20, "R5");
        run_one(1, 4, 0, 2, 20, "R5");

        // R3: a source that never ticks freezes the first high phase
        bus_write(4'h8, 32'h0);
        bus_write(4'h0, {16'd1, 16'd1});
        bus_write(4'h8, ctrl_word(0, 1, 0, 1'b1, 1'b1));
        @(negedge clk);
        bad = 1'b0;
        checks++;
        for (int t = 0; t < 20; t++) begin
            if (!bad && pwm_out[0] !== 1'b1) begin
                bad = 1'b1; errors++;
                $display("FAIL R3: idle source t=%0d actual=%0b expected=1", t, pwm_out[0]);
            end
            @(negedge clk);
        end
        // R3: source 2 ticks every cycle
        bus_write(4'h8, 32'h0);
        bus_write(4'h8, ctrl_word(0, 2, 1, 1'b1, 1'b1));
        @(negedge clk);
        bad = 1'b0;
        checks++;
        for (int t = 0; t < 20; t++) begin
            if (!bad && pwm_out[0] !== model(1, 1, 1, t)) begin
                bad = 1'b1; errors++;
                $display("FAIL R3: source 2 t=%0d actual=%0b expected=%0b", t, pwm_out[0], model(1, 1, 1, t));
            end
            @(negedge clk);
        end

        // R6: output enable without clock enable stays low
        bus_write(4'h8, 32'h0);
        bus_write(4'h0, {16'd2, 16'd2});
        bus_write(4'h8, ctrl_word(0, 0, 0, 1'b0, 1'b1));
        bad = 1'b0;
        checks++;
        for (int t = 0; t < 10; t++) begin
            if (!bad && pwm_out[0] !== 1'b0) begin
                bad = 1'b1; errors++;
                $display("FAIL R6: t=%0d actual=%0b expected=0", t, pwm_out[0]);
            end
            @(negedge clk);
        end

        // R7: disable mid high phase, then restart from a fresh high phase
        bus_write(4'h8, 32'h0);
        bus_write(4'h0, {16'd5, 16'd5});
        bus_write(4'h8, ctrl_word(0, 0, 0, 1'b1, 1'b1));
        @(negedge clk);
        @(negedge clk);
        check_bit(pwm_out[0], 1'b1, "R7", 1);
        bus_write(4'h8, ctrl_word(0, 0, 0, 1'b1, 1'b0));
        check_bit(pwm_out[0], 1'b0, "R7", 2);
        bus_write(4'h8, ctrl_word(0, 0, 0, 1'b1, 1'b1));
        @(negedge clk);
        bad = 1'b0;
        checks++;
        for (int t = 0; t < 20; t++) begin
            if (!bad && pwm_out[0] !== model(5, 5, 0, t)) begin
                bad = 1'b1; errors++;
                $display("FAIL R7: restart t=%0d actual=%0b expected=%0b", t, pwm_out[0], model(5, 5, 0, t));
            end
            @(negedge clk);
        end

        // R8: live rewrite lands at the next period boundary
        bus_write(4'h8, 32'h0);
        bus_write(4'h0, {16'd3, 16'd3});
        bus_write(4'h8, ctrl_word(0, 0, 0, 1'b1, 1'b1));
        @(negedge clk);
        bad = 1'b0;
        checks++;
        for (int t = 0; t < 30; t++) begin
            bit exp;
            exp = (t < 6) ? model(3, 3, 0, t) : model(1, 1, 0, t - 6);
            if (!bad && pwm_out[0] !== exp) begin
                bad = 1'b1; errors++;
                $display("FAIL R8: t=%0d actual=%0b expected=%0b", t, pwm_out[0], exp);
            end
            if (t == 1) begin
                bus_wr = 1'b1; bus_addr = 4'h0; bus_wdata = {16'd1, 16'd1};
            end else begin
                bus_wr = 1'b0;
            end
            @(negedge clk);
        end

        // R9: both channels running together with different setups
        bus_write(4'h8, 32'h0);
        bus_write(4'h0, {16'd2, 16'd1});
        bus_write(4'h4, {16'd1, 16'd3});
        bus_write(4'h8, ctrl_word(0, 0, 1, 1'b1, 1'b1) | ctrl_word(1, 2, 0, 1'b1, 1'b1));
        @(negedge clk);
        bad = 1'b0;
        checks++;
        for (int t = 0; t < 40; t++) begin
            if (!bad && (pwm_out[0] !== model(2, 1, 1, t) || pwm_out[1] !== model(1, 3, 0, t))) begin
                bad = 1'b1; errors++;
                $display("FAIL R9: t=%0d actual=%b expected=%0b%0b", t, pwm_out,
                         model(1, 3, 0, t), model(2, 1, 1, t));
            end
            @(negedge clk);
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule